// File: doc/BRIEF.md
# Programmable Interrupt Source Router

The router gathers a set of peripheral interrupt request lines and steers each one onto one of nine general-purpose priority inputs of a core event controller, levels 7 to 15. The target level of every source comes from its own 4-bit routing field. Software can rewrite these fields through a small register port, so it can move any source to a different level and with that change its effective priority. After reset the fields hold a default map. In that map all error-type sources sit on the most urgent general-purpose level, the clock and first DMA channel sit on the next level, and the serial-port DMA channels sit on the one after it.

Each source also has an enable bit in a mask register. Every level output is the OR of all sources that are enabled and routed to that level, and this OR passes through one register before it leaves the block. A read-only raw status word shows each request line as it is, whatever its enable bit. The peripherals and the core arbiter that consumes the level lines are outside this block.

With the default parameters there are 24 sources. Sources 0 to 15 are the error class, sources 16 and 17 are the clock and DMA channel 0, and sources 18 to 23 are the serial-port DMA channels.

Top module: `irq_router_top`

## Requirements
- R1: For as long as reset is active and after it is released, `lvl_req_o` reads 0 and the mask register (address 3) reads 0, which means every source is disabled.
- R2: After reset the routing registers read their default values. Address 0 reads 0x00000000 and address 1 reads 0x00000000, which routes sources 0 to 15 to field 0. Address 2 reads 0x22222211, which routes sources 16 and 17 to field 1 and sources 18 to 23 to field 2.
- R3: Bit n of `lvl_req_o` stands for core level 7+n. It goes high on the first rising clock edge after any source that is both enabled and has routing field value n is asserted. Until that edge the bit stays at its old value. The bit stays high while any such source remains asserted.
- R4: A source whose mask bit is 0 has no effect on any bit of `lvl_req_o`. Mask bit s enables source s.
- R5: A source whose routing field holds a value from 9 to 15 drives no bit of `lvl_req_o`.
- R6: The field of source s is bits [4*(s%8)+3 : 4*(s%8)] of the register at address s/8. A write to that register changes the routing from the next clock edge on, so the output follows the new field one edge after the write edge.
- R7: Reading address 4 returns `irq_i` in bits [NUM_SRC-1:0], whatever the mask holds. All other bits read 0.
- R8: A write to address 4 or to any address above it leaves every routing field and the mask register unchanged.
- R9: A read of an address above 4 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| irq_i | input | NUM_SRC | Peripheral request lines, active high, synchronous to `clk_i` |
| reg_we_i | input | 1 | Register write strobe, taken on a rising clock edge |
| reg_addr_i | input | ADDR_W | Register address (0 to 2 routing, 3 mask, 4 raw status) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| lvl_req_o | output | 9 | Registered requests to core levels 7 to 15 (bit 0 is level 7) |

## Verification
The assertions assume that `irq_i`, `reg_we_i`, `reg_addr_i` and `reg_wdata_i` are synchronous to `clk_i` and settled before each rising edge. They also assume that each write lasts exactly one cycle with a known address. The bench keeps to this by changing every input only on the falling clock edge. It holds the write strobe for a single cycle, and it reads the combinational read data some time after setting the address, well away from any edge.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int unsigned FIELD_W   = 4;
  localparam int unsigned FPR       = 8;   // fields per 32-bit register
  localparam int unsigned NUM_LVL   = 9;
  localparam int unsigned DATA_W    = 32;

  // Default routing: error class -> field 0, next group -> 1, rest -> 2
  function automatic logic [FIELD_W-1:0] dflt_field(int unsigned src,
                                                    int unsigned n_err,
                                                    int unsigned n_grp1);
    if (src < n_err)               return FIELD_W'(0);
    else if (src < n_err + n_grp1) return FIELD_W'(1);
    else                           return FIELD_W'(2);
  endfunction
endpackage

// File: rtl/irq_rt_rstsync.sv
module irq_rt_rstsync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/irq_rt_regbank.sv
module irq_rt_regbank
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_SRC = 24,
  parameter int unsigned N_ERR   = 16,
  parameter int unsigned N_GRP1  = 2,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_we_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  output logic [NUM_SRC*FIELD_W-1:0] fld_o,
  output logic [NUM_SRC-1:0]         mask_o
);
  localparam int unsigned N_AREG = (NUM_SRC + FPR - 1) / FPR;
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(N_AREG);

  // Routing fields, one small register per source
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_fld
    localparam int unsigned RIDX = s / FPR;
    localparam int unsigned NIB  = s % FPR;
    logic               fld_en;
    logic [FIELD_W-1:0] fld_d;
    logic [FIELD_W-1:0] fld_q;

    always_comb begin
      fld_en = reg_we_i && (reg_addr_i == ADDR_W'(RIDX));
      fld_d  = reg_wdata_i[NIB*FIELD_W +: FIELD_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     fld_q <= dflt_field(s, N_ERR, N_GRP1);
      else if (fld_en) fld_q <= fld_d;
    end

    assign fld_o[s*FIELD_W +: FIELD_W] = fld_q;
  end

  // Mask register
  logic               mask_en;
  logic [NUM_SRC-1:0] mask_d;
  logic [NUM_SRC-1:0] mask_q;

  always_comb begin
    mask_en = reg_we_i && (reg_addr_i == MASK_ADDR);
    mask_d  = reg_wdata_i[NUM_SRC-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R6: a mask write lands on the next edge
  p_mask_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == MASK_ADDR) |=> (mask_o == $past(reg_wdata_i[NUM_SRC-1:0])));

  // R8: writes at or above the status address leave all state unchanged
  p_ro_fields_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i > MASK_ADDR) |=> $stable(fld_o));

  p_ro_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i > MASK_ADDR) |=> $stable(mask_o));
endmodule

// File: rtl/irq_rt_route.sv
module irq_rt_route
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_SRC = 24
) (
  input  logic [NUM_SRC-1:0]         irq_i,
  input  logic [NUM_SRC-1:0]         mask_i,
  input  logic [NUM_SRC*FIELD_W-1:0] fld_i,
  output logic [NUM_LVL-1:0]         lvl_o
);
  logic [NUM_SRC-1:0] live;
  assign live = irq_i & mask_i;

  // One OR tree per level; field values >= NUM_LVL match no level
  for (genvar n = 0; n < NUM_LVL; n++) begin : g_lvl
    logic [NUM_SRC-1:0] sel;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign sel[s] = live[s] && (fld_i[s*FIELD_W +: FIELD_W] == FIELD_W'(n));
    end
    assign lvl_o[n] = |sel;
  end
endmodule

// File: rtl/irq_rt_rdmux.sv
module irq_rt_rdmux
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_SRC = 24,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM_SRC*FIELD_W-1:0] fld_i,
  input  logic [NUM_SRC-1:0]         mask_i,
  input  logic [NUM_SRC-1:0]         irq_i,
  output logic [DATA_W-1:0]          rdata_o
);
  localparam int unsigned N_AREG    = (NUM_SRC + FPR - 1) / FPR;
  localparam int unsigned N_SLOT    = N_AREG * FPR;
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(N_AREG);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(N_AREG + 1);

  logic [N_SLOT*FIELD_W-1:0] words;

  // Pack fields into whole register words, padding unused slots with zero
  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    if (i < NUM_SRC) begin : g_used
      assign words[i*FIELD_W +: FIELD_W] = fld_i[i*FIELD_W +: FIELD_W];
    end else begin : g_pad
      assign words[i*FIELD_W +: FIELD_W] = '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) < N_AREG) begin
      rdata_o = words[int'(addr_i)*DATA_W +: DATA_W];
    end else if (addr_i == MASK_ADDR) begin
      rdata_o[NUM_SRC-1:0] = mask_i;
    end else if (addr_i == STAT_ADDR) begin
      rdata_o[NUM_SRC-1:0] = irq_i;
    end
  end
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_SRC = 24,
  parameter int unsigned N_ERR   = 16,
  parameter int unsigned N_GRP1  = 2,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic [8:0]         lvl_req_o
);
  logic                       rst_sync_n;
  logic [NUM_SRC*FIELD_W-1:0] fld_w;
  logic [NUM_SRC-1:0]         mask_w;
  logic [NUM_LVL-1:0]         lvl_d;
  logic [NUM_LVL-1:0]         lvl_q;

  irq_rt_rstsync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  irq_rt_regbank #(
    .NUM_SRC(NUM_SRC), .N_ERR(N_ERR), .N_GRP1(N_GRP1), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .fld_o      (fld_w),
    .mask_o     (mask_w)
  );

  irq_rt_route #(.NUM_SRC(NUM_SRC)) u_route (
    .irq_i (irq_i),
    .mask_i(mask_w),
    .fld_i (fld_w),
    .lvl_o (lvl_d)
  );

  irq_rt_rdmux #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_rd (
    .addr_i (reg_addr_i),
    .fld_i  (fld_w),
    .mask_i (mask_w),
    .irq_i  (irq_i),
    .rdata_o(reg_rdata_o)
  );

  // Output stage: one register on every level line
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) lvl_q <= '0;
    else             lvl_q <= lvl_d;
  end

  assign lvl_req_o = lvl_q;

  // R4: with no enabled request, all levels are low one edge later
  p_masked_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((irq_i & mask_w) == '0) |=> (lvl_req_o == '0));

  // R3: a raised level always has an enabled request one cycle before it
  p_lvl_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (lvl_req_o != '0) |-> $past((irq_i & mask_w) != '0));

  // R1: outputs are low while reset is applied
  always_comb begin
    if (!rst_sync_n) begin
      p_reset_low_r1: assert (lvl_q == '0);
    end
  end
endmodule

// File: tb/irq_router_top_tb_top.sv
module irq_router_top_tb_top;
  localparam int NSRC = 24;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] irq;
  logic            we;
  logic [2:0]      addr;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic [8:0]      lvl;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irq_router_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .lvl_req_o(lvl)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // set irq on a falling edge, then sample one falling edge later
  task automatic drive_irq(input logic [NSRC-1:0] v);
    @(negedge clk);
    irq = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 lvl in reset", {23'd0, lvl}, 32'd0);
    bus_read(3'd3, d); check("R1 mask after reset", d, 32'd0);
    bus_read(3'd0, d); check("R2 routing word 0", d, 32'h0000_0000);
    bus_read(3'd1, d); check("R2 routing word 1", d, 32'h0000_0000);
    bus_read(3'd2, d); check("R2 routing word 2", d, 32'h2222_2211);
    drive_irq(24'hFF_FFFF);
    check("R1 R4 all masked after reset", {23'd0, lvl}, 32'd0);
    drive_irq('0);
  endtask

  task automatic t_default_route;
    bus_write(3'd3, 32'h00FF_FFFF);
    drive_irq(24'h00_0020);
    check("R3 src5 to level7", {23'd0, lvl}, 32'h001);
    drive_irq(24'h02_0000);
    check("R3 src17 to level8", {23'd0, lvl}, 32'h002);
    drive_irq(24'h10_0000);
    check("R3 src20 to level9", {23'd0, lvl}, 32'h004);
    drive_irq(24'h10_8001);
    check("R3 mixed levels", {23'd0, lvl}, 32'h005);
    drive_irq('0);
    check("R3 all released", {23'd0, lvl}, 32'd0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    irq = 24'h00_0004;
    #1 check("R3 no change before edge", {23'd0, lvl}, 32'd0);
    @(negedge clk);
    check("R3 high after one edge", {23'd0, lvl}, 32'h001);
    drive_irq('0);
  endtask

  task automatic t_or_merge;
    drive_irq(24'h00_0003);
    check("R3 two sources one level", {23'd0, lvl}, 32'h001);
    drive_irq(24'h00_0002);
    check("R3 level held by other source", {23'd0, lvl}, 32'h001);
    drive_irq('0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    bus_write(3'd3, 32'h00FF_FFDF);
    drive_irq(24'h00_0020);
    check("R4 masked src5 quiet", {23'd0, lvl}, 32'd0);
    bus_read(3'd4, d);
    check("R7 raw status shows masked src5", d, 32'h0000_0020);
    bus_write(3'd3, 32'h00FF_FFFF);
    @(negedge clk);
    check("R4 unmask lets src5 through", {23'd0, lvl}, 32'h001);
    drive_irq('0);
  endtask

  task automatic t_reassign;
    logic [31:0] d;
    bus_write(3'd0, 32'h0000_8000);
    bus_read(3'd0, d);
    check("R6 readback word 0", d, 32'h0000_8000);
    drive_irq(24'h00_0008);
    check("R6 src3 now level15", {23'd0, lvl}, 32'h100);
    drive_irq(24'h00_0004);
    check("R6 src2 unchanged level7", {23'd0, lvl}, 32'h001);
    bus_write(3'd2, 32'h2222_2251);
    drive_irq(24'h02_0000);
    check("R6 src17 now level12", {23'd0, lvl}, 32'h020);
    drive_irq('0);
  endtask

  task automatic t_bad_field;
    for (int v = 9; v < 16; v++) begin
      bus_write(3'd0, 32'(v) << 12);
      drive_irq(24'h00_0008);
      check($sformatf("R5 field %0d routes nowhere", v), {23'd0, lvl}, 32'd0);
      drive_irq('0);
    end
    bus_write(3'd0, 32'h0000_0000);
  endtask

  task automatic t_read_only;
    logic [31:0] d;
    bus_write(3'd4, 32'h0000_0000);
    bus_write(3'd5, 32'hFFFF_FFFF);
    bus_write(3'd7, 32'h0000_0000);
    bus_read(3'd3, d); check("R8 mask kept", d, 32'h00FF_FFFF);
    bus_read(3'd0, d); check("R8 word 0 kept", d, 32'h0000_0000);
    bus_read(3'd2, d); check("R8 word 2 kept", d, 32'h2222_2251);
    bus_read(3'd5, d); check("R9 unmapped 5 reads zero", d, 32'd0);
    bus_read(3'd7, d); check("R9 unmapped 7 reads zero", d, 32'd0);
    irq = 24'hA5_0F0F;
    bus_read(3'd4, d); check("R7 status pattern", d, 32'h00A5_0F0F);
    irq = '0;
  endtask

  initial begin
    rst_n = 1'b0; irq = '0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 lvl during reset", {23'd0, lvl}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_default_route();
    t_latency();
    t_or_merge();
    t_mask();
    t_reassign();
    t_bad_field();
    t_read_only();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule